// File: doc/BRIEF.md
# Shared-Adder ALU with Control Decode

This block is a two's-complement arithmetic and logic unit of configurable width. All of its arithmetic runs through one carry chain. A small decoder turns a 3-bit operation code into four control lines. One line is an active-low enable that can force the B operand to zero. A second inverts the conditioned B operand. The third is the adder's carry-in, and the fourth chooses between the adder sum and the bitwise XOR of A with the conditioned B. With these lines the single adder covers add, subtract, increment, decrement and two compare operations. The XOR operation uses the same conditioned B operand.

The block returns a result word and five flags: zero, negative, signed overflow, signed less-than and equality. By default a parameter places one register stage after the logic, so results appear one clock after the operands. When that parameter is cleared the block is purely combinational.

Top module: `shared_adder_alu`

## Requirements
- R1: Opcode 3'b000 (add) gives result = A + B modulo 2^W.
- R2: Opcode 3'b001 (subtract) gives result = A - B modulo 2^W.
- R3: Opcode 3'b010 (increment) gives result = A + 1 modulo 2^W, and B has no effect.
- R4: Opcode 3'b011 (decrement) gives result = A - 1 modulo 2^W, and B has no effect.
- R5: Opcode 3'b110 (XOR) gives result = A ^ B, and the overflow flag is 0.
- R6: Opcode 3'b100 (less-than compare) gives result = A - B. The lt flag is 1 exactly when signed A < signed B, and this includes operands at the range limits. On every other opcode the lt flag is 0.
- R7: Opcode 3'b101 (equality compare) gives result = A - B. The eq flag is 1 exactly when A == B. On every other opcode the eq flag is 0.
- R8: For every defined opcode, the zero flag is 1 when the result is all zeros and the negative flag equals the result's most significant bit.
- R9: For opcodes 3'b000 to 3'b101, the overflow flag is 1 exactly when the true signed value of the operation does not fit in W bits.
- R10: Opcode 3'b111 is unused. It drives an all-zero result and clears all five flags.
- R11: With REG_OUT=1, the outputs show the operation whose operands were present at the previous rising clock edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 3 | Operation code |
| a | input | W | Operand A |
| b | input | W | Operand B |
| result | output | W | Result word |
| zero_f | output | 1 | Result is all zeros |
| neg_f | output | 1 | Result sign bit |
| ovf_f | output | 1 | Signed overflow of an arithmetic operation |
| lt_f | output | 1 | Signed A < B (less-than compare only) |
| eq_f | output | 1 | A equals B (equality compare only) |

## Verification
The hardest case to reach is a less-than compare in which the subtraction overflows. In that case the raw sign bit gives the wrong answer, and only the overflow correction makes the flag right. Random operands seldom land there. The stimulus therefore crosses every opcode with the most negative value, the most positive value, zero, one and all-ones on both operands, which reaches these cases directly. Random operands are added on top of that. Every response is compared with a reference model that computes each result in wide signed integers.

// File: rtl/shared_adder_alu.sv
module shared_adder_alu #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         zero_f,
  output logic         neg_f,
  output logic         ovf_f,
  output logic         lt_f,
  output logic         eq_f
);
  localparam logic [2:0] OP_ADD = 3'b000;
  localparam logic [2:0] OP_SUB = 3'b001;
  localparam logic [2:0] OP_INC = 3'b010;
  localparam logic [2:0] OP_DEC = 3'b011;
  localparam logic [2:0] OP_LT  = 3'b100;
  localparam logic [2:0] OP_EQ  = 3'b101;
  localparam logic [2:0] OP_XOR = 3'b110;

  logic b_keep, b_inv, cin, sel_sum, arith, valid;

  always_comb begin
    b_keep = 1'b1; b_inv = 1'b0; cin = 1'b0; sel_sum = 1'b1;
    arith = 1'b1; valid = 1'b1;
    unique case (op)
      OP_ADD: ;
      OP_SUB, OP_LT, OP_EQ: begin b_inv = 1'b1; cin = 1'b1; end
      OP_INC: begin b_keep = 1'b0; cin = 1'b1; end
      OP_DEC: begin b_keep = 1'b0; b_inv = 1'b1; end
      OP_XOR: begin sel_sum = 1'b0; arith = 1'b0; end
      default: begin valid = 1'b0; arith = 1'b0; end
    endcase
  end

  logic [W-1:0] bcond, sum, res_c;
  logic         cout, c_msb, ovf_c, zero_c, neg_c, lt_c, eq_c;

  assign bcond = (b_keep ? b : '0) ^ {W{b_inv}};
  assign {cout, sum} = {1'b0, a} + {1'b0, bcond} + {{W{1'b0}}, cin};
  assign c_msb  = a[W-1] ^ bcond[W-1] ^ sum[W-1];
  assign ovf_c  = arith & (cout ^ c_msb);
  assign res_c  = !valid ? '0 : (sel_sum ? sum : (a ^ bcond));
  assign zero_c = valid & (res_c == '0);
  assign neg_c  = res_c[W-1];
  assign lt_c   = (op == OP_LT) & (sum[W-1] ^ ovf_c);
  assign eq_c   = (op == OP_EQ) & (sum == '0);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result <= '0;
          {zero_f, neg_f, ovf_f, lt_f, eq_f} <= '0;
        end else begin
          result <= res_c;
          {zero_f, neg_f, ovf_f, lt_f, eq_f} <= {zero_c, neg_c, ovf_c, lt_c, eq_c};
        end
      end
    end else begin : g_comb
      assign result = res_c;
      assign {zero_f, neg_f, ovf_f, lt_f, eq_f} = {zero_c, neg_c, ovf_c, lt_c, eq_c};
    end
  endgenerate

  AST_INC_IGNORES_B: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC) |-> (res_c == a + W'(1))); // R3
  AST_DEC_IGNORES_B: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DEC) |-> (res_c == a - W'(1))); // R4
  AST_XOR_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XOR) |-> (!ovf_c && res_c == (a ^ b))); // R5
  AST_LT_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LT) |-> (lt_c == ($signed(a) < $signed(b)))); // R6
  AST_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EQ) |-> (eq_c == (a == b))); // R7
  AST_UNUSED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b111) |-> (res_c == '0 && !zero_c && !ovf_c && !lt_c && !eq_c)); // R10
  AST_FLAGS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lt_c, eq_c})); // R6
endmodule

// File: tb/sim_shared_adder_alu.sv
module sim_shared_adder_alu;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [W-1:0] a = '0, b = '0, result;
  logic zero_f, neg_f, ovf_f, lt_f, eq_f;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  shared_adder_alu #(.W(W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .result(result),
    .zero_f(zero_f), .neg_f(neg_f), .ovf_f(ovf_f), .lt_f(lt_f), .eq_f(eq_f));

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R6"; 3'd5: return "R7"; 3'd6: return "R5"; default: return "R10";
    endcase
  endfunction

  task automatic run(input logic [2:0] o, input logic [W-1:0] xa, input logic [W-1:0] xb);
    longint sa, sb, v;
    logic [W-1:0] er;
    logic ez, en, eo, el, ee;
    @(negedge clk);
    op = o; a = xa; b = xb;
    sa = longint'($signed(xa)); sb = longint'($signed(xb));
    case (o)
      3'd0: v = sa + sb;
      3'd1, 3'd4, 3'd5: v = sa - sb;
      3'd2: v = sa + 1;
      3'd3: v = sa - 1;
      default: v = 0;
    endcase
    er = (o == 3'd6) ? (xa ^ xb) : W'(v);
    eo = (o <= 3'd5) && (v > 32767 || v < -32768);
    el = (o == 3'd4) && (sa < sb);
    ee = (o == 3'd5) && (xa == xb);
    ez = (o != 3'd7) && (er == '0);
    en = er[W-1];
    @(negedge clk);
    checks++;
    if (result !== er || zero_f !== ez || neg_f !== en || ovf_f !== eo || lt_f !== el || eq_f !== ee) begin
      fails++;
      $display("FAIL %s/R8/R9 op=%0d a=%h b=%h actual=%h z%b n%b o%b l%b e%b expected=%h z%b n%b o%b l%b e%b",
               req_of(o), o, xa, xb, result, zero_f, neg_f, ovf_f, lt_f, eq_f, er, ez, en, eo, el, ee);
    end
  endtask

  logic [W-1:0] corner [5] = '{16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h0001};

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R11 reset state
    if ({result, zero_f, neg_f, ovf_f, lt_f, eq_f} !== '0) begin
      fails++; $display("FAIL R11 reset actual=%h expected=0", result);
    end
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run(3'(o), corner[i], corner[j]);
    for (int o = 0; o < 8; o++)
      for (int k = 0; k < 300; k++)
        run(3'(o), W'($urandom), W'($urandom));
    for (int k = 0; k < 50; k++) begin
      logic [W-1:0] r = W'($urandom);
      run(3'd5, r, r);  // R7 equal operands
      run(3'd1, r, r);  // R8 zero result
    end
    @(negedge clk);
    op = 3'd0; a = 16'h1234; b = 16'h1111;
    @(posedge clk); #1 rst_n = 1'b0;
    #2;
    checks++; // R11 asynchronous clear
    if ({result, zero_f, neg_f, ovf_f, lt_f, eq_f} !== '0) begin
      fails++; $display("FAIL R11 async reset actual=%h expected=0", result);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule